// File: doc/BRIEF.md
# Cascaded Seven-Channel DMA Request Arbiter

This block holds the request and priority logic for a DMA subsystem built from two four-slot controllers. The lower controller serves channels 0 to 3. The upper controller serves channels 5 to 7. Its slot 4 is permanently given over to carrying the lower controller's combined request. Hardware request lines and a software request register both raise requests. Per-channel mask bits suppress them. The block grants one channel at a time on a one-hot acknowledge bus and signals the bus side through a hold-request line.

Software reaches the request, mask and mode settings through a small write port, and every write takes effect on the clock edge where it is sampled. An end-of-transfer pulse clears the software request of the channel being acknowledged. All pins are plain control signals. The block carries no data stream, so it has no valid/ready interface and no back-pressure. Address and count registers, the transfer engine and any bus protocol belong to other blocks.

Top module: `dma_cascade_arb`

## Requirements
- R1: After reset, `dack_o` and `hrq_o` are 0. Channels 0–3 and 5–7 are masked. Channel 4 is unmasked and in cascade mode, so requests on masked channels produce no acknowledge.
- R2: At most one bit of `dack_o` is ever set. A request that is unmasked and stable is acknowledged on the first rising edge after it is presented.
- R3: `dack_o[4]` is never set, and `dreq_i[4]` has no effect on `dack_o` or `hrq_o`.
- R4: Priority among pending channels runs 0, 1, 2, 3, 5, 6, 7, with channel 0 highest. Any request in channels 0–3 beats every request in channels 5–7.
- R5: A mask write (`wr_addr_i`=1) uses `wr_data_i[2:0]` as the channel and `wr_data_i[3]` as the new mask bit (1 = masked). A masked channel is never acknowledged.
- R6: Once a channel is acknowledged, its acknowledge is held for as long as its request stays active and unmasked, even if a higher-priority request arrives. When its request is withdrawn, the acknowledge passes to the highest pending channel, or to none.
- R7: A request write (`wr_addr_i`=0) sets (`wr_data_i[3]`=1) or clears (`wr_data_i[3]`=0) the software request of channel `wr_data_i[2:0]`. A set software request is served exactly like a hardware request. A request write that names channel 4 is ignored.
- R8: When `eop_i` is high at a rising edge, the software request of the channel then acknowledged is cleared.
- R9: A mode write (`wr_addr_i`=2) uses `wr_data_i[2:0]` as the channel and `wr_data_i[5:4]` as the mode, with 2'b11 meaning cascade. Such a write to channel 4 with any other mode is ignored, so channels 0–3 stay reachable. Masking channel 4 blocks all of channels 0–3. Address 3 is ignored.
- R10: `hrq_o` is 1 on the first rising edge after any unmasked request on channels 0–3 or 5–7 is present, and otherwise 0. It is never 0 while `dack_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq_i | input | 8 | Hardware request per channel; bit 4 is ignored |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 request, 1 mask, 2 mode |
| wr_data_i | input | 8 | Write data: channel in [2:0], set bit in [3], mode in [5:4] |
| eop_i | input | 1 | End of transfer for the acknowledged channel |
| dack_o | output | 8 | One-hot acknowledge; bit 4 always 0 |
| hrq_o | output | 1 | Hold request to the bus side |

## Verification
A hardware request change driven before an edge shows on `dack_o` and `hrq_o` after that single edge. A register write or an `eop_i` pulse needs two edges: one to update the stored state and one to re-register the grant. The bench drives every input on the falling edge and samples outputs on a later falling edge. It waits one cycle after request changes and two after writes or end-of-transfer pulses, so each check lands on a settled output. The hold checks wait extra cycles to show that the acknowledge does not move.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned NCH    = 2 * SLOTS;
  localparam int unsigned CAS_CH = SLOTS;
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_DEMAND  = 2'b00,
    MODE_SINGLE  = 2'b01,
    MODE_BLOCK   = 2'b10,
    MODE_CASCADE = 2'b11
  } chan_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REQ  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MODE = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_fixed_prio.sv
module dma_fixed_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eop_i,
  input  logic [NCH-1:0]    dack_i,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    sreq_o,
  output logic              cas_ok_o
);
  localparam logic [NCH-1:0] MASK_RST = ~(NCH'(1) << CAS_CH);

  logic [NCH-1:0] mask_q, mask_d;
  logic [NCH-1:0] sreq_q, sreq_d;
  chan_mode_e     cas_mode_q, cas_mode_d;
  logic [CH_W-1:0] sel_ch;
  logic           set_bit;
  chan_mode_e     wr_mode;
  logic           unused_data;

  assign sel_ch      = wr_data_i[CH_W-1:0];
  assign set_bit     = wr_data_i[3];
  assign wr_mode     = chan_mode_e'(wr_data_i[5:4]);
  assign unused_data = ^wr_data_i[DATA_W-1:6];

  always_comb begin
    mask_d     = mask_q;
    sreq_d     = sreq_q & ~(eop_i ? dack_i : '0);
    cas_mode_d = cas_mode_q;
    if (wr_en_i) begin
      case (reg_sel_e'(wr_addr_i))
        SEL_REQ:  if (sel_ch != CH_W'(CAS_CH)) sreq_d[sel_ch] = set_bit;
        SEL_MASK: mask_d[sel_ch] = set_bit;
        SEL_MODE: if (sel_ch == CH_W'(CAS_CH) && wr_mode == MODE_CASCADE)
                    cas_mode_d = MODE_CASCADE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= MASK_RST;
      sreq_q     <= '0;
      cas_mode_q <= MODE_CASCADE;
    end else begin
      mask_q     <= mask_d;
      sreq_q     <= sreq_d;
      cas_mode_q <= cas_mode_d;
    end
  end

  assign mask_o   = mask_q;
  assign sreq_o   = sreq_q;
  assign cas_ok_o = (cas_mode_q == MODE_CASCADE);

  a_r9_cascade_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cas_mode_q == MODE_CASCADE);
  a_r3_no_soft_slot4: assert property (@(posedge clk) disable iff (!rst_n)
    !sreq_q[CAS_CH]);
  a_r8_eop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_i && !wr_en_i) |=> ((sreq_q & $past(dack_i)) == '0));
endmodule

// File: rtl/dma_grant_hold.sv
module dma_grant_hold
  import dma_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_eff_i,
  input  logic [NCH-1:0] win_i,
  output logic [NCH-1:0] dack_o,
  output logic           hrq_o
);
  logic [NCH-1:0] dack_q, dack_d;
  logic           hrq_q;
  logic           keep;

  assign keep   = |(dack_q & req_eff_i);
  assign dack_d = keep ? dack_q : win_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dack_q <= '0;
      hrq_q  <= 1'b0;
    end else begin
      dack_q <= dack_d;
      hrq_q  <= |req_eff_i;
    end
  end

  assign dack_o = dack_q;
  assign hrq_o  = hrq_q;

  a_r2_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_q));
  a_r6_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack_q != '0) && ((dack_q & req_eff_i) != '0)) |=> $stable(dack_q));
  a_r10_hrq_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q != '0) |-> hrq_q);
endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    dreq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eop_i,
  output logic [NCH-1:0]    dack_o,
  output logic              hrq_o
);
  logic [NCH-1:0]   mask_q, sreq_q, raw, req_eff, win;
  logic             cas_ok, cas_open;
  logic [SLOTS-1:0] lo_req, lo_gnt, hi_req, hi_gnt;
  logic             lo_any, hi_any;

  dma_arb_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .eop_i     (eop_i),
    .dack_i    (dack_o),
    .mask_o    (mask_q),
    .sreq_o    (sreq_q),
    .cas_ok_o  (cas_ok)
  );

  assign raw      = (dreq_i | sreq_q) & ~mask_q;
  assign cas_open = cas_ok & ~mask_q[CAS_CH];
  assign lo_req   = raw[SLOTS-1:0] & {SLOTS{cas_open}};

  dma_fixed_prio #(.N(SLOTS)) u_lo_prio (
    .req_i (lo_req),
    .gnt_o (lo_gnt),
    .any_o (lo_any)
  );

  assign hi_req = {raw[NCH-1:CAS_CH+1], lo_any};

  dma_fixed_prio #(.N(SLOTS)) u_hi_prio (
    .req_i (hi_req),
    .gnt_o (hi_gnt),
    .any_o (hi_any)
  );

  assign req_eff = {raw[NCH-1:CAS_CH+1], 1'b0, lo_req};
  assign win = !hi_any    ? '0 :
               hi_gnt[0]  ? {{SLOTS{1'b0}}, lo_gnt} :
                            {hi_gnt[SLOTS-1:1], 1'b0, {SLOTS{1'b0}}};

  dma_grant_hold u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_eff_i (req_eff),
    .win_i     (win),
    .dack_o    (dack_o),
    .hrq_o     (hrq_o)
  );

  a_r3_no_slot4_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !dack_o[CAS_CH]);
  a_r5_masked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dack_o & $past(mask_q)) == '0));
  a_r4_lower_first: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_o == '0 && lo_any) |=> (dack_o[NCH-1:CAS_CH] == '0));
endmodule

// File: tb/tb_dma_cascade_arb.sv
module tb_dma_cascade_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dreq = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       eop = 1'b0;
  logic [7:0] dack;
  logic       hrq;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_cascade_arb dut (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .eop_i(eop),
    .dack_o(dack), .hrq_o(hrq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic t_reset;
    check("R1 dack after reset", dack, 8'h00);
    check("R1 hrq after reset", {7'd0, hrq}, 8'h00);
    dreq = 8'hFF; cycles(2);
    check("R1 masked at reset dack", dack, 8'h00);
    check("R1 masked at reset hrq", {7'd0, hrq}, 8'h00);
    dreq = 8'h00;
    for (int c = 0; c < 8; c++) if (c != 4) reg_write(2'd1, 8'(c));
    cycles(1);
  endtask

  task automatic t_priority;
    dreq = 8'b1110_1110; cycles(1);
    check("R4 lowest wins", dack, 8'b0000_0010);
    check("R10 hrq with request", {7'd0, hrq}, 8'h01);
    dreq = 8'b1110_0000; cycles(1);
    check("R4 upper controller after withdraw", dack, 8'b0010_0000);
    dreq = 8'b1100_0000; cycles(1);
    check("R4 next upper channel", dack, 8'b0100_0000);
    dreq = 8'h00; cycles(1);
    check("R2 no request no ack", dack, 8'h00);
    check("R10 hrq low", {7'd0, hrq}, 8'h00);
  endtask

  task automatic t_hold;
    dreq = 8'b0100_0000; cycles(1);
    check("R6 ack ch6", dack, 8'b0100_0000);
    dreq = 8'b0100_0001; cycles(3);
    check("R6 held despite ch0", dack, 8'b0100_0000);
    dreq = 8'b0000_0001; cycles(1);
    check("R6 passes to ch0", dack, 8'b0000_0001);
    dreq = 8'h00; cycles(1);
  endtask

  task automatic t_slot4;
    dreq = 8'b0001_0000; cycles(2);
    check("R3 dreq4 no ack", dack, 8'h00);
    check("R3 dreq4 no hrq", {7'd0, hrq}, 8'h00);
    dreq = 8'h00;
  endtask

  task automatic t_mask;
    reg_write(2'd1, 8'b0000_1010);
    dreq = 8'b0000_0100; cycles(2);
    check("R5 masked ch2 no ack", dack, 8'h00);
    check("R5 masked ch2 no hrq", {7'd0, hrq}, 8'h00);
    reg_write(2'd1, 8'b0000_0010); cycles(1);
    check("R5 unmasked ch2 acked", dack, 8'b0000_0100);
    reg_write(2'd1, 8'b0000_1010); cycles(1);
    check("R5 masking active ch2 drops ack", dack, 8'h00);
    dreq = 8'h00;
    reg_write(2'd1, 8'b0000_0010); cycles(1);
  endtask

  task automatic t_soft;
    reg_write(2'd0, 8'b0000_1011); cycles(1);
    check("R7 soft request ch3 acked", dack, 8'b0000_1000);
    eop = 1'b1; @(negedge clk); eop = 1'b0; cycles(1);
    check("R8 eop clears soft ch3", dack, 8'h00);
    check("R8 no hrq after clear", {7'd0, hrq}, 8'h00);
    reg_write(2'd0, 8'b0000_1100); cycles(2);
    check("R7 soft write ch4 ignored", dack, 8'h00);
    reg_write(2'd0, 8'b0000_1110); cycles(1);
    check("R7 soft ch6 acked", dack, 8'b0100_0000);
    reg_write(2'd0, 8'b0000_0110); cycles(1);
    check("R7 soft clear ch6", dack, 8'h00);
  endtask

  task automatic t_cascade;
    reg_write(2'd2, 8'b0000_0100);
    reg_write(2'd2, 8'b0001_0100);
    reg_write(2'd3, 8'b0000_1001);
    dreq = 8'b0000_0001; cycles(1);
    check("R9 ch0 reachable after mode write", dack, 8'b0000_0001);
    dreq = 8'b0010_0001;
    reg_write(2'd1, 8'b0000_1100); cycles(1);
    check("R9 masking ch4 moves ack to ch5", dack, 8'b0010_0000);
    reg_write(2'd1, 8'b0000_0100);
    dreq = 8'b0000_0001; cycles(1);
    check("R9 ch4 unmasked ch0 back", dack, 8'b0000_0001);
    dreq = 8'h00; cycles(1);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_priority();
    t_hold();
    t_slot4();
    t_mask();
    t_soft();
    t_cascade();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule